// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block turns four independent reset requests into four per-domain reset outputs for a network controller. The requests are an active-low board reset pin, a host-issued full soft reset, and two PHY-only resets: one from the power-management control path and one from the PHY's own control register. Each request is stretched to a defined width, accepted only in the states where it is allowed, and routed only to the domains it affects. The domains are the host bus interface, the MAC, the PHY, and a group of registers that a soft reset must not clear.

After the board reset and after a full soft reset, the block starts a configuration reload from the external EEPROM and raises a busy flag until the reload engine reports done. Software must treat that flag as blocking EEPROM access, GPIO function changes and MAC-address writes. After the board reset only, it also gives one pulse that latches the configuration straps. After any reset that touches the PHY, `xfer_en` holds off data transfer until the PHY reports link.

The sequencer has five states. `ST_HOLD` (all domains in reset, stretch count running) moves to `ST_LOAD` when the count ends. `ST_LOAD` (reload running, busy set) moves to `ST_READY` when `ee_done` is sampled. From `ST_READY` (idle), a soft request moves to `ST_SOFT` and a PHY request moves to `ST_PHY`. `ST_SOFT` (host, MAC and PHY in reset) moves to `ST_LOAD` after `PULSE_LEN` cycles. `ST_PHY` (PHY in reset) returns to `ST_READY` after `PULSE_LEN` cycles, or moves to `ST_SOFT` on a soft request. A low level on the pin forces `ST_HOLD` from any state.

Top module: `rst_ctrl`

## Requirements
- R1: While `hw_rst_n` is low, all four domain reset outputs are low, and `ready`, `ee_busy` and `xfer_en` are 0. The outputs go low without waiting for a clock edge.
- R2: After `hw_rst_n` rises, all four domain outputs rise together on rising clock edge number `HOLD_CYCLES`+3.
- R3: `strap_latch` is a single-cycle pulse. It is given only at the end of the hardware hold, in the same cycle that `ee_busy` rises, and never after a soft or PHY reset.
- R4: `ee_reload_start` pulses for one cycle as `ee_busy` rises. `ee_busy` stays high until `ee_done` is sampled, and `ready` is 0 while `ee_busy` is 1. `ready` is 1 after the reload ends.
- R5: `soft_rst_req` is accepted at any clock edge where `ready` is 1. It is ignored while `ready` is 0, with no domain output changing.
- R6: An accepted soft reset drives `rst_hbi_n`, `rst_mac_n` and `rst_phy_n` low for exactly `PULSE_LEN`+1 cycles and leaves `rst_nasr_n` high. It is followed by a reload (R4) without a strap pulse.
- R7: A PHY reset from either `phy_rst_pm_req` or `phy_rst_bc_req`, accepted while `ready` is 1, drives only `rst_phy_n` low, for exactly `PULSE_LEN`+1 cycles. It starts no reload, and `ready` stays 1.
- R8: PHY reset requests are ignored while `ready` is 0.
- R9: `xfer_en` is 0 after any reset of the PHY domain. It becomes 1 one cycle after `phy_link_up` is sampled high while `rst_phy_n` and `ready` are high, and it stays 1 until the next PHY-domain reset.
- R10: When a soft request and a PHY request arrive in the same cycle, the soft reset takes effect (R6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| hw_rst_n | input | 1 | Board reset pin, active low, asynchronous |
| soft_rst_req | input | 1 | Full soft reset request (one-cycle pulse) |
| phy_rst_pm_req | input | 1 | PHY reset request from power-management control |
| phy_rst_bc_req | input | 1 | PHY reset request from the PHY control register |
| ee_done | input | 1 | EEPROM reload engine finished |
| phy_link_up | input | 1 | PHY link status |
| rst_hbi_n | output | 1 | Host bus interface reset, active low |
| rst_mac_n | output | 1 | MAC reset, active low |
| rst_phy_n | output | 1 | PHY reset, active low |
| rst_nasr_n | output | 1 | Reset of registers kept through soft reset, active low |
| strap_latch | output | 1 | One-cycle strap capture strobe |
| ee_reload_start | output | 1 | One-cycle EEPROM reload start |
| ee_busy | output | 1 | EEPROM reload in progress |
| ready | output | 1 | Device ready; soft reset allowed |
| xfer_en | output | 1 | Data transfer allowed (link seen since last PHY reset) |

## Verification
The bench builds the block with `HOLD_CYCLES` = 20 and `PULSE_LEN` = 16. The short hold lets many board resets, each with its exact `HOLD_CYCLES`+3 release edge, fit into one run. It also lets a board reset be mixed at random among soft and PHY resets. The EEPROM reload latency is randomised per reset, and one directed reload is made long enough that soft and PHY requests can be issued while `ee_busy` is high, which shows they are ignored.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_LOAD,
        ST_READY,
        ST_SOFT,
        ST_PHY
    } rc_state_e;

    localparam int DOM_N    = 4;
    localparam int DOM_HBI  = 0;
    localparam int DOM_MAC  = 1;
    localparam int DOM_PHY  = 2;
    localparam int DOM_NASR = 3;

    // Which domains are held in reset in each state
    function automatic logic [DOM_N-1:0] dom_mask(rc_state_e s);
        logic [DOM_N-1:0] m;
        m = '0;
        unique case (s)
            ST_HOLD:  m = '1;
            ST_SOFT:  begin
                m[DOM_HBI] = 1'b1;
                m[DOM_MAC] = 1'b1;
                m[DOM_PHY] = 1'b1;
            end
            ST_PHY:   m[DOM_PHY] = 1'b1;
            default:  m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rst_ctrl_sync.sv
// Reset output stage: asserts asynchronously on the pin, synchronously on
// hold; releases through two flops.
module rst_ctrl_sync (
    input  logic clk,
    input  logic arst_n,
    input  logic hold,
    output logic rst_out_n
);
    logic meta_q;
    logic out_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            meta_q <= 1'b0;
            out_q  <= 1'b0;
        end else if (hold) begin
            meta_q <= 1'b0;
            out_q  <= 1'b0;
        end else begin
            meta_q <= 1'b1;
            out_q  <= meta_q;
        end
    end

    assign rst_out_n = out_q;
endmodule

// File: rtl/rst_ctrl_fsm.sv
module rst_ctrl_fsm
    import rst_ctrl_pkg::*;
#(
    parameter int HOLD_CYCLES = 750000,
    parameter int PULSE_LEN   = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      soft_req,
    input  logic      phy_req,
    input  logic      ee_done,
    output rc_state_e state_nxt,
    output logic      strap_pulse,
    output logic      ee_start,
    output logic      ee_busy,
    output logic      ready
);
    localparam int MAXC = (HOLD_CYCLES > PULSE_LEN) ? HOLD_CYCLES : PULSE_LEN;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYCLES - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_LEN - 1);

    rc_state_e     state_q;
    logic [CW-1:0] cnt_q;

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_HOLD:  if (cnt_q == HOLD_LAST) state_nxt = ST_LOAD;
            ST_LOAD:  if (ee_done) state_nxt = ST_READY;
            ST_READY: begin
                if (soft_req)     state_nxt = ST_SOFT;
                else if (phy_req) state_nxt = ST_PHY;
            end
            ST_SOFT:  if (cnt_q == PULSE_LAST) state_nxt = ST_LOAD;
            ST_PHY: begin
                if (soft_req)                 state_nxt = ST_SOFT;
                else if (cnt_q == PULSE_LAST) state_nxt = ST_READY;
            end
            default:  state_nxt = ST_HOLD;
        endcase
    end

    // state register and stretch counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nxt;
            if (state_nxt != state_q) cnt_q <= '0;
            else if (state_q inside {ST_HOLD, ST_SOFT, ST_PHY}) cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_pulse <= 1'b0;
            ee_start    <= 1'b0;
        end else begin
            strap_pulse <= (state_q == ST_HOLD) && (state_nxt == ST_LOAD);
            ee_start    <= (state_q != ST_LOAD) && (state_nxt == ST_LOAD);
        end
    end

    assign ee_busy = (state_q == ST_LOAD);
    assign ready   = (state_q == ST_READY) || (state_q == ST_PHY);
endmodule

// File: rtl/rst_ctrl.sv
module rst_ctrl
    import rst_ctrl_pkg::*;
#(
    parameter int HOLD_CYCLES = 750000,
    parameter int PULSE_LEN   = 16
) (
    input  logic clk,
    input  logic hw_rst_n,
    input  logic soft_rst_req,
    input  logic phy_rst_pm_req,
    input  logic phy_rst_bc_req,
    input  logic ee_done,
    input  logic phy_link_up,
    output logic rst_hbi_n,
    output logic rst_mac_n,
    output logic rst_phy_n,
    output logic rst_nasr_n,
    output logic strap_latch,
    output logic ee_reload_start,
    output logic ee_busy,
    output logic ready,
    output logic xfer_en
);
    logic             core_rst_n;
    rc_state_e        state_nxt;
    logic [DOM_N-1:0] dom_req;
    logic [DOM_N-1:0] dom_rst_n;
    logic             link_ok_q;

    // pin synchronizer for the sequencer itself
    rst_ctrl_sync u_por (
        .clk       (clk),
        .arst_n    (hw_rst_n),
        .hold      (1'b0),
        .rst_out_n (core_rst_n)
    );

    rst_ctrl_fsm #(
        .HOLD_CYCLES (HOLD_CYCLES),
        .PULSE_LEN   (PULSE_LEN)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (core_rst_n),
        .soft_req    (soft_rst_req),
        .phy_req     (phy_rst_pm_req | phy_rst_bc_req),
        .ee_done     (ee_done),
        .state_nxt   (state_nxt),
        .strap_pulse (strap_latch),
        .ee_start    (ee_reload_start),
        .ee_busy     (ee_busy),
        .ready       (ready)
    );

    // domain requests taken from the next state, so assertion lines up
    // with state entry
    assign dom_req = dom_mask(state_nxt);

    for (genvar g = 0; g < DOM_N; g++) begin : g_dom
        rst_ctrl_sync u_dom (
            .clk       (clk),
            .arst_n    (hw_rst_n),
            .hold      (dom_req[g]),
            .rst_out_n (dom_rst_n[g])
        );
    end

    assign rst_hbi_n  = dom_rst_n[DOM_HBI];
    assign rst_mac_n  = dom_rst_n[DOM_MAC];
    assign rst_phy_n  = dom_rst_n[DOM_PHY];
    assign rst_nasr_n = dom_rst_n[DOM_NASR];

    // link gate: cleared by any PHY-domain reset, set by link seen
    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n)               link_ok_q <= 1'b0;
        else if (dom_req[DOM_PHY])     link_ok_q <= 1'b0;
        else if (phy_link_up && dom_rst_n[DOM_PHY]) link_ok_q <= 1'b1;
    end

    assign xfer_en = link_ok_q && ready;
endmodule

// File: rtl/rst_ctrl_chk.sv
module rst_ctrl_chk (
    input logic clk,
    input logic hw_rst_n,
    input logic soft_rst_req,
    input logic phy_rst_pm_req,
    input logic phy_rst_bc_req,
    input logic rst_hbi_n,
    input logic rst_mac_n,
    input logic rst_phy_n,
    input logic rst_nasr_n,
    input logic strap_latch,
    input logic ee_reload_start,
    input logic ee_busy,
    input logic ready,
    input logic xfer_en
);
    AST_STRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!hw_rst_n)
        strap_latch |=> !strap_latch); // R3
    AST_STRAP_WITH_BUSY: assert property (@(posedge clk) disable iff (!hw_rst_n)
        strap_latch |-> ee_busy); // R3
    AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!hw_rst_n)
        ee_reload_start |-> ee_busy); // R4
    AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!hw_rst_n)
        !(ready && ee_busy)); // R4
    AST_SOFT_ACCEPTED: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (ready && soft_rst_req) |=> (!rst_mac_n && !rst_hbi_n && !rst_phy_n)); // R5
    AST_NASR_KEPT: assert property (@(posedge clk) disable iff (!hw_rst_n)
        rst_nasr_n |=> rst_nasr_n); // R6
    AST_PHY_ACCEPTED: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (ready && !soft_rst_req && (phy_rst_pm_req || phy_rst_bc_req)) |=> !rst_phy_n); // R7
    AST_PHY_ONLY: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (ready && !rst_phy_n) |-> (rst_mac_n && rst_hbi_n)); // R7
    AST_XFER_GATED: assert property (@(posedge clk) disable iff (!hw_rst_n)
        xfer_en |-> (rst_phy_n && ready)); // R9
endmodule

bind rst_ctrl rst_ctrl_chk u_chk (
    .clk             (clk),
    .hw_rst_n        (hw_rst_n),
    .soft_rst_req    (soft_rst_req),
    .phy_rst_pm_req  (phy_rst_pm_req),
    .phy_rst_bc_req  (phy_rst_bc_req),
    .rst_hbi_n       (rst_hbi_n),
    .rst_mac_n       (rst_mac_n),
    .rst_phy_n       (rst_phy_n),
    .rst_nasr_n      (rst_nasr_n),
    .strap_latch     (strap_latch),
    .ee_reload_start (ee_reload_start),
    .ee_busy         (ee_busy),
    .ready           (ready),
    .xfer_en         (xfer_en)
);

// File: tb/test_rst_ctrl.sv
module test_rst_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 20;
    localparam int PULSE      = 16;
    localparam int WIN        = PULSE + 6;
    localparam int WDOG       = 150000;

    logic clk = 1'b0;
    logic hw_rst_n = 1'b1;
    logic soft_rst_req = 1'b0, phy_rst_pm_req = 1'b0, phy_rst_bc_req = 1'b0;
    logic ee_done = 1'b0, phy_link_up = 1'b0;
    logic rst_hbi_n, rst_mac_n, rst_phy_n, rst_nasr_n;
    logic strap_latch, ee_reload_start, ee_busy, ready, xfer_en;

    int n_chk = 0;
    int n_fail = 0;
    int ee_lat = 3;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_ctrl #(.HOLD_CYCLES(HOLD), .PULSE_LEN(PULSE)) i_rst_ctrl (
        .clk(clk), .hw_rst_n(hw_rst_n), .soft_rst_req(soft_rst_req),
        .phy_rst_pm_req(phy_rst_pm_req), .phy_rst_bc_req(phy_rst_bc_req),
        .ee_done(ee_done), .phy_link_up(phy_link_up),
        .rst_hbi_n(rst_hbi_n), .rst_mac_n(rst_mac_n), .rst_phy_n(rst_phy_n),
        .rst_nasr_n(rst_nasr_n), .strap_latch(strap_latch),
        .ee_reload_start(ee_reload_start), .ee_busy(ee_busy),
        .ready(ready), .xfer_en(xfer_en));

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected low-sample count per domain (0 hbi,1 mac,2 phy,3 nasr)
    // kind: 0 soft, 1 pm phy, 2 bc phy, 3 soft+phy together
    function automatic int exp_low(int kind, int dom);
        if (dom == 3) return 0;
        if (kind == 0 || kind == 3) return PULSE + 1;
        return (dom == 2) ? PULSE + 1 : 0;
    endfunction

    function automatic int exp_start(int kind);
        return (kind == 0 || kind == 3) ? 1 : 0;
    endfunction

    // EEPROM engine model
    initial begin
        forever begin
            @(negedge clk);
            if (ee_reload_start === 1'b1) begin
                repeat (ee_lat) @(negedge clk);
                ee_done = 1'b1;
                @(negedge clk);
                ee_done = 1'b0;
            end
        end
    end

    task automatic wait_ready(string req);
        int both = 0;
        int i = 0;
        while (ready !== 1'b1 && i < 500) begin
            @(negedge clk);
            if (ready === 1'b1 && ee_busy === 1'b1) both++;
            i++;
        end
        chk({req, " ready after reload"}, int'(ready), 1);
        chk({req, " busy cleared"}, int'(ee_busy), 0);
        chk({req, " ready with busy"}, both, 0);
    endtask

    task automatic hw_reset(int low_cycles);
        int first = 0;
        int strap = 0;
        int mism = 0;
        @(negedge clk);
        #2 hw_rst_n = 1'b0;
        #1;
        chk("R1 outputs low", int'({rst_hbi_n, rst_mac_n, rst_phy_n, rst_nasr_n}), 0);
        chk("R1 status low", int'({ready, ee_busy, xfer_en}), 0);
        repeat (low_cycles) @(negedge clk);
        hw_rst_n = 1'b1;
        for (int n = 1; n <= HOLD + 20; n++) begin
            @(negedge clk);
            if (strap_latch) strap++;
            if (rst_mac_n && first == 0) first = n;
            if ({rst_hbi_n, rst_phy_n, rst_nasr_n} != {3{rst_mac_n}}) mism++;
        end
        chk("R2 release edge", first, HOLD + 3);
        chk("R2 domains together", mism, 0);
        chk("R3 strap pulses", strap, 1);
        wait_ready("R4 hw");
    endtask

    task automatic pulse(int kind, output int lows[4], output int starts,
                         output int straps, output int rdy_low);
        lows = '{0, 0, 0, 0};
        starts = 0; straps = 0; rdy_low = 0;
        @(negedge clk);
        soft_rst_req   = (kind == 0 || kind == 3);
        phy_rst_pm_req = (kind == 1 || kind == 3);
        phy_rst_bc_req = (kind == 2);
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (i == 0) begin
                soft_rst_req = 1'b0; phy_rst_pm_req = 1'b0; phy_rst_bc_req = 1'b0;
            end
            if (!rst_hbi_n)  lows[0]++;
            if (!rst_mac_n)  lows[1]++;
            if (!rst_phy_n)  lows[2]++;
            if (!rst_nasr_n) lows[3]++;
            if (ee_reload_start) starts++;
            if (strap_latch) straps++;
            if (!ready) rdy_low++;
        end
    endtask

    task automatic run_op(int kind);
        int lows[4];
        int st, sp, rl;
        string tag;
        tag = (kind == 0) ? "R6 soft" : (kind == 3) ? "R10 soft+phy" :
              (kind == 1) ? "R7 phy pm" : "R7 phy bc";
        pulse(kind, lows, st, sp, rl);
        for (int d = 0; d < 4; d++) chk({tag, " domain low cycles"}, lows[d], exp_low(kind, d));
        chk({tag, " reload start"}, st, exp_start(kind));
        chk("R3 no strap after soft/phy", sp, 0);
        if (exp_start(kind) == 0) chk("R7 ready held", rl, 0);
        else wait_ready("R4 soft");
        // link gate
        chk("R9 xfer blocked after PHY reset", int'(xfer_en), 0);
        phy_link_up = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9 xfer after link", int'(xfer_en), 1);
        phy_link_up = 1'b0;
    endtask

    task automatic ignored_while_busy();
        int lows[4];
        int st, sp, rl;
        ee_lat = 60;
        pulse(0, lows, st, sp, rl);
        chk("R4 busy during reload", int'(ee_busy), 1);
        chk("R4 not ready during reload", int'(ready), 0);
        pulse(0, lows, st, sp, rl);
        chk("R5 soft ignored mac", lows[1], 0);
        chk("R5 soft ignored phy", lows[2], 0);
        pulse(1, lows, st, sp, rl);
        chk("R8 pm ignored", lows[2], 0);
        pulse(2, lows, st, sp, rl);
        chk("R8 bc ignored", lows[2], 0);
        ee_lat = 4;
        wait_ready("R4 long");
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", WDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        #3;
        hw_reset(5);
        chk("R9 xfer low after hw reset", int'(xfer_en), 0);
        phy_link_up = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R9 xfer after link", int'(xfer_en), 1);
        phy_link_up = 1'b0;
        run_op(0);
        run_op(1);
        run_op(2);
        run_op(3);
        ignored_while_busy();
        for (int it = 0; it < 40; it++) begin
            int k;
            k = int'($urandom % 5);
            ee_lat = 1 + int'($urandom % 12);
            if (k == 4) hw_reset(1 + int'($urandom % 8));
            else run_op(k);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule